// File: doc/BRIEF.md
# Word-Parallel BCH Parity Encoder

This block produces the check bits of a shortened binary BCH code while the message streams in several bits at a time. A fixed update matrix is derived at elaboration from the code's generator polynomial. Each accepted data word is combined with the top slice of the parity register and multiplied by that matrix. The product is then merged with the shifted register, so one clock cycle does the work of as many steps of a bit-serial divider as the word is wide.

The block also takes one extra message bit on a dedicated single-bit input. That bit belongs to a nonlinear code built around the linear one. It is not a separate step: it is XORed onto the earliest bit of the first data word. A start pulse opens a message. Words are taken only while the valid input is high, so the source may pause at any point. After the final word a one-cycle completion pulse appears, and the check bits then stay put until the next start. With the default sizes (8200 message bits, 70 check bits, 10 bits per word) a message takes 820 accepted words.

Top module: `parallel_bch_encoder`

## Requirements
- R1: After reset, `parity` is all zero, `wordCount` is zero and `done` is low.
- R2: A cycle with `start` high clears `parity` and `wordCount` to zero in the next cycle. A data word offered in that same cycle is not absorbed.
- R3: Each accepted word updates the register to (parity shifted up by PAR_W) XOR the product of ((top PAR_W parity bits) XOR word) with the update matrix. Row i of the matrix is x^(PAR_BITS+i) mod g(x). Word bit PAR_W-1 is the earliest message bit. After the last word, `parity` equals the remainder of m(x)·x^PAR_BITS divided by g(x), with parity bit PAR_BITS-1 as the highest coefficient.
- R4: `msbIn` is XORed onto bit PAR_W-1 of the word accepted while `wordCount` is zero, and has no effect on any later word.
- R5: In a cycle where `dataValid` is low, `parity` and `wordCount` keep their values.
- R6: `done` is high for exactly one cycle: the cycle right after the MSG_BITS/PAR_W-th accepted word. `parity` already holds the final check bits in that cycle.
- R7: After completion, `parity` and `wordCount` hold their values, and valid words are ignored, until the next `start`.
- R8: `wordCount` rises by one per accepted word and ends at MSG_BITS/PAR_W.
- R9: A `start` in the middle of a message abandons that message. The next message is encoded as if nothing had come before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Opens a new message and clears the state |
| dataIn | input | PAR_W | Message word, earliest bit in the top position |
| dataValid | input | 1 | Qualifies `dataIn` |
| msbIn | input | 1 | Extra message bit, folded into the first word |
| wordCount | output | CNT_W | Number of words accepted since `start` |
| done | output | 1 | One-cycle completion pulse |
| parity | output | PAR_BITS | Check-bit register |

## Verification
The bench runs the same messages through a one-bit-wide and a two-bit-wide instance and compares both against a bit-serial division computed in the bench. A bit-order or matrix-row mistake therefore shows up as a disagreement between the two widths and the reference.

Messages with the extra bit set and with it clear catch three faults: a fold applied to every word, a fold applied to the wrong bit, or a fold left out. Idle cycles placed between words catch a register or counter that moves without `dataValid`. Words offered alongside `start`, after completion, and in a restarted message catch leaked state, a completion pulse that is stretched or misplaced, and check bits that drift after the end.

// File: rtl/bchenc_pkg.sv
package bchenc_pkg;

  // Strobes from the sequencer to the parity datapath.
  typedef struct packed {
    logic clear;    // zero the register
    logic advance;  // absorb the current word
    logic first;    // current word is the first of the message
  } encStrobe_t;

endpackage

// File: rtl/bchenc_ctrl.sv
module bchenc_ctrl
  import bchenc_pkg::*;
#(
  parameter int WORDS = 820,
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             dataValid,
  output encStrobe_t       strobe,
  output logic [CNT_W-1:0] wordCount,
  output logic             done
);

  logic [CNT_W-1:0] cnt;
  logic             busy;
  logic             lastWord;

  assign lastWord = (cnt == CNT_W'(WORDS - 1));

  always_comb begin
    strobe.clear   = start;
    strobe.advance = busy && dataValid && !start;
    strobe.first   = (cnt == '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt  <= '0;
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        cnt  <= '0;
        busy <= 1'b1;
      end else if (busy && dataValid) begin
        cnt <= cnt + 1'b1;
        if (lastWord) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign wordCount = cnt;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R6
  AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (cnt == CNT_W'(WORDS))); // R6
  AST_COUNT_CEILING: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= CNT_W'(WORDS)); // R8
  AST_START_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    start |=> (cnt == '0)); // R9
  AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> $stable(cnt)); // R7

endmodule

// File: rtl/bchenc_dpath.sv
module bchenc_dpath
  import bchenc_pkg::*;
#(
  parameter int                  PAR_BITS = 70,
  parameter int                  PAR_W    = 10,
  parameter logic [PAR_BITS-1:0] GEN_POLY = '1
) (
  input  logic                clk,
  input  logic                rstN,
  input  encStrobe_t          strobe,
  input  logic [PAR_W-1:0]    dataIn,
  input  logic                msbIn,
  output logic [PAR_BITS-1:0] parity
);

  // Row idx of the update matrix: x^(PAR_BITS+idx) mod g(x).
  function automatic logic [PAR_BITS-1:0] powRow(input int idx);
    logic [PAR_BITS-1:0] t;
    t = GEN_POLY;
    for (int n = 0; n < idx; n++)
      t = {t[PAR_BITS-2:0], 1'b0} ^ (t[PAR_BITS-1] ? GEN_POLY : '0);
    return t;
  endfunction

  logic [PAR_BITS-1:0]             parReg;
  logic [PAR_BITS-1:0]             shifted;
  logic [PAR_BITS-1:0]             nextPar;
  logic [PAR_W-1:0]                wordEff;
  logic [PAR_W-1:0]                fbVec;
  logic [PAR_W-1:0][PAR_BITS-1:0]  terms;

  assign wordEff = dataIn ^ (PAR_W'(strobe.first & msbIn) << (PAR_W - 1));
  assign fbVec   = parReg[PAR_BITS-1 -: PAR_W] ^ wordEff;
  assign shifted = parReg << PAR_W;

  for (genvar i = 0; i < PAR_W; i++) begin : g_row
    localparam logic [PAR_BITS-1:0] ROW = powRow(i);
    assign terms[i] = ROW & {PAR_BITS{fbVec[i]}};
  end

  always_comb begin
    nextPar = shifted;
    for (int i = 0; i < PAR_W; i++) nextPar ^= terms[i];
  end

  always_ff @(posedge clk) begin
    if (!rstN)               parReg <= '0;
    else if (strobe.clear)   parReg <= '0;
    else if (strobe.advance) parReg <= nextPar;
  end

  assign parity = parReg;

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clear |=> (parReg == '0)); // R2
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.clear && !strobe.advance) |=> $stable(parReg)); // R5

endmodule

// File: rtl/parallel_bch_encoder.sv
module parallel_bch_encoder
  import bchenc_pkg::*;
#(
  parameter int                  MSG_BITS = 8200,
  parameter int                  PAR_BITS = 70,
  parameter int                  PAR_W    = 10,
  parameter logic [PAR_BITS-1:0] GEN_POLY = 70'h23A5C91E70F4BD861,
  localparam int                 WORDS    = MSG_BITS / PAR_W,
  localparam int                 CNT_W    = $clog2(WORDS + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic [PAR_W-1:0]    dataIn,
  input  logic                dataValid,
  input  logic                msbIn,
  output logic [CNT_W-1:0]    wordCount,
  output logic                done,
  output logic [PAR_BITS-1:0] parity
);

  encStrobe_t strobe;

  bchenc_ctrl #(.WORDS(WORDS), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .dataValid(dataValid),
    .strobe(strobe), .wordCount(wordCount), .done(done)
  );

  bchenc_dpath #(.PAR_BITS(PAR_BITS), .PAR_W(PAR_W), .GEN_POLY(GEN_POLY)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .dataIn(dataIn),
    .msbIn(msbIn), .parity(parity)
  );

endmodule

// File: tb/parallel_bch_encoder_tb.sv
module parallel_bch_encoder_tb;

  localparam logic [7:0] GEN = 8'hD1;  // x^8+x^7+x^6+x^4+1, shortened to 6 message bits

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic msb = 1'b0;
  logic sData = 1'b0;
  logic sValid = 1'b0;
  logic [1:0] pData = '0;
  logic pValid = 1'b0;
  logic [2:0] sCnt;
  logic [1:0] pCnt;
  logic sDone, pDone;
  logic [7:0] sPar, pPar;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  bit ended = 0;

  always #10 clk = ~clk;

  parallel_bch_encoder #(.MSG_BITS(6), .PAR_BITS(8), .PAR_W(2), .GEN_POLY(GEN)) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .dataIn(pData), .dataValid(pValid),
    .msbIn(msb), .wordCount(pCnt), .done(pDone), .parity(pPar));

  parallel_bch_encoder #(.MSG_BITS(6), .PAR_BITS(8), .PAR_W(1), .GEN_POLY(GEN)) u_dutSer (
    .clk(clk), .rstN(rstN), .start(start), .dataIn(sData), .dataValid(sValid),
    .msbIn(msb), .wordCount(sCnt), .done(sDone), .parity(sPar));

  // message[12:7], extra bit[6], idle-before-bit mask[5:0]
  localparam logic [12:0] VEC [8] = '{
    {6'b000000, 1'b0, 6'b000000},
    {6'b100000, 1'b0, 6'b000000},
    {6'b000001, 1'b0, 6'b000000},
    {6'b101101, 1'b1, 6'b010100},
    {6'b111111, 1'b0, 6'b000001},
    {6'b000000, 1'b1, 6'b000000},
    {6'b010110, 1'b1, 6'b111111},
    {6'b110011, 1'b0, 6'b001010}
  };

  function automatic logic [7:0] refRem(input logic [5:0] m, input logic x);
    logic [7:0] s = '0;
    for (int j = 5; j >= 0; j--) begin
      logic b = m[j] ^ ((j == 5) ? x : 1'b0);
      logic fb = b ^ s[7];
      s = {s[6:0], 1'b0} ^ (fb ? GEN : 8'h00);
    end
    return s;
  endfunction

  task automatic check(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic runMsg(input logic [5:0] m, input logic x, input logic [5:0] gaps, input string req);
    logic [7:0] exp, sHold, pHold;
    exp = refRem(m, x);
    @(negedge clk); start = 1; sValid = 0; pValid = 0; msb = x;
    @(negedge clk); start = 0;
    for (int j = 5; j >= 0; j--) begin
      if (gaps[j]) begin
        sValid = 0; pValid = 0; sData = ~sData; pData = ~pData;
        sHold = sPar; pHold = pPar;
        @(negedge clk);
        check("R5", "serial parity across idle", sPar, sHold);
        check("R5", "parallel parity across idle", pPar, pHold);
      end
      sValid = 1; sData = m[j];
      pValid = (j % 2 == 0);
      if (j % 2 == 0) pData = {m[j+1], m[j]};
      @(negedge clk);
    end
    sValid = 0; pValid = 0;
    check("R6", "serial done", 8'(sDone), 8'd1);
    check("R6", "parallel done", 8'(pDone), 8'd1);
    check(req, "serial parity", sPar, exp);
    check(req, "parallel parity", pPar, exp);
    check("R8", "serial count", 8'(sCnt), 8'd6);
    check("R8", "parallel count", 8'(pCnt), 8'd3);
    sValid = 1; pValid = 1; sData = 1; pData = 2'b11;
    @(negedge clk);
    sValid = 0; pValid = 0;
    check("R6", "serial done low", 8'(sDone), 8'd0);
    check("R6", "parallel done low", 8'(pDone), 8'd0);
    check("R7", "serial parity held", sPar, exp);
    check("R7", "parallel parity held", pPar, exp);
    check("R7", "parallel count held", 8'(pCnt), 8'd3);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !ended) begin
      ended = 1;
      mismatched++;
      compared++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check("R1", "parity at reset", sPar | pPar, 8'h00);
    check("R1", "count at reset", 8'(sCnt) | 8'(pCnt), 8'h00);
    check("R1", "done at reset", 8'(sDone | pDone), 8'h00);

    // Word offered together with start is not absorbed (R2).
    start = 1; sValid = 1; sData = 1; pValid = 1; pData = 2'b11;
    @(negedge clk);
    start = 0; sValid = 0; pValid = 0;
    check("R2", "serial parity after start", sPar, 8'h00);
    check("R2", "parallel parity after start", pPar, 8'h00);
    check("R2", "serial count after start", 8'(sCnt), 8'h00);

    // Partial message, then a restart (R9).
    msb = 1;
    for (int j = 0; j < 3; j++) begin
      sValid = 1; sData = 1; pValid = (j != 1); pData = 2'b10;
      @(negedge clk);
    end
    sValid = 0; pValid = 0;
    runMsg(6'b011010, 1'b0, 6'b000000, "R9");

    // Table walk: main function and extra-bit fold (R3, R4).
    for (int v = 0; v < 8; v++) begin
      runMsg(VEC[v][12:7], VEC[v][6], VEC[v][5:0], VEC[v][6] ? "R4" : "R3");
    end

    // The extra bit alone must equal a message with only its earliest bit set (R4).
    check("R4", "fold equivalence", refRem(6'b000000, 1'b1), refRem(6'b100000, 1'b0));

    ended = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule